// File: doc/BRIEF.md
# Invalidation Privilege Trap Checker

This block sits in the decode stage and decides whether an address-translation invalidate or one of its companion ordering fences may run in the current privilege mode. The opcode decoder gives it one of five instruction classes, along with the current mode and the two trap-on-virtual-memory control bits. The first control bit comes from machine status (`tvm`). The second comes from hypervisor status and governs guests (`vtvm`).

The three invalidates follow the permission rules of the full translation fences they replace. Each can be trapped under control of the bits. The two ordering fences only order memory traffic and have no visible side effect, so both control bits leave them alone. When a class is refused, the block chooses between an illegal-instruction trap and a virtual-instruction trap according to the mode.

The decision is registered. It appears one cycle after the request, together with a valid strobe, and it stays unchanged until the next request. The parameter `HYP_EN` removes the hypervisor classes. The two guest invalidates are then always illegal.

Top module: `inv_trap_check`

## Requirements
- R1: During and right after reset, `rsp_valid` is 0 and `rsp_trap` is 0 (no trap).
- R2: `rsp_valid` equals `req_valid` delayed by exactly one clock cycle. The `rsp_trap` shown with it is decided from the class, mode, `tvm` and `vtvm` sampled in the cycle `req_valid` was high.
- R3: `rsp_trap` codes are 0 = none, 1 = illegal-instruction, 2 = virtual-instruction, and 3 never appears. Inputs presented while `req_valid` is 0 have no effect, and `rsp_trap` keeps its last value.
- R4: In user mode (mode code 2), every class gets trap code 1. The class codes are: 0 supervisor invalidate, 1 guest-virtual invalidate, 2 guest-physical invalidate, 3 write-before-invalidate fence, 4 invalidate-before-implicit-read fence.
- R5: In machine mode (mode code 0) with `HYP_EN`=1, no class traps, whatever `tvm` and `vtvm` are.
- R6: In supervisor/hypervisor-supervisor mode (mode code 1), the supervisor invalidate and the guest-physical invalidate get trap code 1 when `tvm`=1. Every other combination in this mode gets 0.
- R7: In virtual-supervisor mode (mode code 3), the guest-virtual and guest-physical invalidates get trap code 2.
- R8: In virtual-supervisor mode, the supervisor invalidate gets trap code 2 exactly when `vtvm`=1, and 0 otherwise. `tvm` plays no part.
- R9: In virtual-user mode (mode code 4), every class gets trap code 2.
- R10: The two fence classes get 0 in modes 1 and 3 for all four combinations of `tvm` and `vtvm`.
- R11: With `HYP_EN`=0, class codes 1 and 2 get trap code 1 in every mode, machine mode included.
- R12: Class codes 5 to 7 get 0 in modes 0 to 4. Mode codes 5 to 7 give trap code 1 for every class code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A class is presented this cycle |
| req_class | input | 3 | Instruction class code (see R4) |
| priv_mode | input | 3 | Mode code: 0 machine, 1 supervisor/hypervisor-supervisor, 2 user, 3 virtual-supervisor, 4 virtual-user |
| tvm | input | 1 | Machine-status trap-virtual-memory bit |
| vtvm | input | 1 | Hypervisor-status virtual trap-virtual-memory bit |
| rsp_valid | output | 1 | Decision valid, one cycle after `req_valid` |
| rsp_trap | output | 2 | Trap decision code (see R3) |

## Verification
The bench builds two copies of the block side by side from the same stimulus. Instance `u0` keeps the default `HYP_EN`=1, which brings the full mode table within reach, including the split between illegal and virtual traps. Instance `u1` uses `HYP_EN`=0, which makes the rule that forces the guest invalidates to illegal observable, even in machine mode. Every combination of class, mode and both control bits is swept on `u0` against a model written per class, and the unused codes and the hold behaviour are driven directly.

// File: rtl/inv_trap_pkg.sv
package inv_trap_pkg;

  localparam int CLS_W  = 3;
  localparam int MODE_W = 3;
  localparam int TRAP_W = 2;

  // instruction classes
  localparam logic [CLS_W-1:0] CLS_SINV  = 3'd0;
  localparam logic [CLS_W-1:0] CLS_GVINV = 3'd1;
  localparam logic [CLS_W-1:0] CLS_GPINV = 3'd2;
  localparam logic [CLS_W-1:0] CLS_FWR   = 3'd3;
  localparam logic [CLS_W-1:0] CLS_FIR   = 3'd4;

  // privilege modes
  localparam logic [MODE_W-1:0] MD_M  = 3'd0;
  localparam logic [MODE_W-1:0] MD_S  = 3'd1;
  localparam logic [MODE_W-1:0] MD_U  = 3'd2;
  localparam logic [MODE_W-1:0] MD_VS = 3'd3;
  localparam logic [MODE_W-1:0] MD_VU = 3'd4;

  typedef enum logic [TRAP_W-1:0] {
    TRAP_NONE = 2'd0,
    TRAP_ILL  = 2'd1,
    TRAP_VIRT = 2'd2
  } trap_e;

  function automatic logic is_guest(input logic [CLS_W-1:0] c);
    return (c == CLS_GVINV) || (c == CLS_GPINV);
  endfunction

  function automatic logic is_fence(input logic [CLS_W-1:0] c);
    return (c == CLS_FWR) || (c == CLS_FIR);
  endfunction

  function automatic logic is_known(input logic [CLS_W-1:0] c);
    return c <= CLS_FIR;
  endfunction

  // Whole permission rule; priority: bad mode, missing hypervisor, table.
  function automatic trap_e trap_rule(input logic [CLS_W-1:0] c,
                                      input logic [MODE_W-1:0] m,
                                      input logic t_vm, input logic vt_vm,
                                      input bit hyp);
    trap_e r;
    r = TRAP_NONE;
    if (m > MD_VU)                    r = TRAP_ILL;
    else if (!hyp && is_guest(c))     r = TRAP_ILL;
    else if (!is_known(c))            r = TRAP_NONE;
    else begin
      case (m)
        MD_M:  r = TRAP_NONE;
        MD_S:  if (((c == CLS_SINV) || (c == CLS_GPINV)) && t_vm) r = TRAP_ILL;
        MD_U:  r = TRAP_ILL;
        MD_VS: if (is_guest(c) || ((c == CLS_SINV) && vt_vm))     r = TRAP_VIRT;
        default: r = TRAP_VIRT;  // MD_VU
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/inv_trap_rules.sv
module inv_trap_rules
  import inv_trap_pkg::*;
#(
  parameter bit HYP_EN = 1'b1
) (
  input  logic [CLS_W-1:0]  cls,
  input  logic [MODE_W-1:0] mode,
  input  logic              t_vm,
  input  logic              vt_vm,
  output logic [TRAP_W-1:0] trap
);
  always_comb trap = trap_rule(cls, mode, t_vm, vt_vm, HYP_EN);
endmodule

// File: rtl/inv_trap_stage.sv
module inv_trap_stage #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_dat <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_dat <= in_dat;
    end
  end
endmodule

// File: rtl/inv_trap_check.sv
module inv_trap_check
  import inv_trap_pkg::*;
#(
  parameter bit HYP_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_class,
  input  logic [2:0]  priv_mode,
  input  logic        tvm,
  input  logic        vtvm,
  output logic        rsp_valid,
  output logic [1:0]  rsp_trap
);
  // combinational decision, named for the checker
  logic [TRAP_W-1:0] dec_trap;

  inv_trap_rules #(.HYP_EN(HYP_EN)) u_rules (
    .cls   (req_class),
    .mode  (priv_mode),
    .t_vm  (tvm),
    .vt_vm (vtvm),
    .trap  (dec_trap)
  );

  inv_trap_stage #(.W(TRAP_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (req_valid),
    .in_dat  (dec_trap),
    .out_vld (rsp_valid),
    .out_dat (rsp_trap)
  );
endmodule

// File: rtl/inv_trap_check_sva.sv
module inv_trap_check_sva
  import inv_trap_pkg::*;
#(
  parameter bit HYP_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [2:0]  req_class,
  input logic [2:0]  priv_mode,
  input logic        tvm,
  input logic        vtvm,
  input logic        rsp_valid,
  input logic [1:0]  rsp_trap,
  input logic [1:0]  dec_trap
);
  logic cls_fence, cls_guest, cls_known;
  assign cls_fence = (req_class == 3'd3) || (req_class == 3'd4);
  assign cls_guest = (req_class == 3'd1) || (req_class == 3'd2);
  assign cls_known = req_class < 3'd5;

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!rsp_valid && rsp_trap == 2'd0));                          // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);                                              // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);                                            // R2

  AST_RESULT_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_trap == $past(dec_trap)));                          // R2

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap != 2'd3);                                                     // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_trap));                                     // R3

  AST_USER_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && priv_mode == 3'd2 && cls_known) |=> rsp_trap == 2'd1);   // R4

  AST_MACHINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && priv_mode == 3'd0 && cls_known && (HYP_EN || !cls_guest))
      |=> rsp_trap == 2'd0);                                               // R5

  AST_VU_VIRTUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && priv_mode == 3'd4 && cls_known && HYP_EN) |=> rsp_trap == 2'd2); // R9

  AST_FENCE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cls_fence && (priv_mode == 3'd1 || priv_mode == 3'd3))
      |=> rsp_trap == 2'd0);                                               // R10

  AST_NO_HYP_GUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !HYP_EN && cls_guest) |=> rsp_trap == 2'd1);             // R11
endmodule

bind inv_trap_check inv_trap_check_sva #(.HYP_EN(HYP_EN)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_class (req_class),
  .priv_mode (priv_mode),
  .tvm       (tvm),
  .vtvm      (vtvm),
  .rsp_valid (rsp_valid),
  .rsp_trap  (rsp_trap),
  .dec_trap  (dec_trap)
);

// File: tb/sim_inv_trap_check.sv
module sim_inv_trap_check;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 26;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_class, priv_mode;
  logic       tvm, vtvm;
  logic       v0, v1;
  logic [1:0] t0, t1;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inv_trap_check #(.HYP_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .priv_mode(priv_mode), .tvm(tvm), .vtvm(vtvm), .rsp_valid(v0), .rsp_trap(t0));

  inv_trap_check #(.HYP_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .priv_mode(priv_mode), .tvm(tvm), .vtvm(vtvm), .rsp_valid(v1), .rsp_trap(t1));

  // {class, mode, tvm, vtvm, expected trap}
  localparam logic [9:0] VEC [NVEC] = '{
    {3'd0,3'd0,1'b1,1'b1,2'd0}, {3'd2,3'd0,1'b1,1'b1,2'd0}, {3'd4,3'd0,1'b1,1'b1,2'd0}, // R5
    {3'd0,3'd2,1'b0,1'b0,2'd1}, {3'd1,3'd2,1'b0,1'b0,2'd1}, {3'd3,3'd2,1'b1,1'b1,2'd1},
    {3'd4,3'd2,1'b0,1'b0,2'd1},                                                         // R4
    {3'd0,3'd1,1'b1,1'b0,2'd1}, {3'd0,3'd1,1'b0,1'b1,2'd0}, {3'd2,3'd1,1'b1,1'b0,2'd1},
    {3'd1,3'd1,1'b1,1'b1,2'd0},                                                         // R6
    {3'd3,3'd1,1'b1,1'b1,2'd0}, {3'd4,3'd1,1'b1,1'b1,2'd0},                             // R10
    {3'd1,3'd3,1'b0,1'b0,2'd2}, {3'd2,3'd3,1'b0,1'b0,2'd2},                             // R7
    {3'd0,3'd3,1'b0,1'b1,2'd2}, {3'd0,3'd3,1'b1,1'b0,2'd0},                             // R8
    {3'd3,3'd3,1'b1,1'b1,2'd0}, {3'd4,3'd3,1'b1,1'b1,2'd0},                             // R10
    {3'd0,3'd4,1'b0,1'b0,2'd2}, {3'd1,3'd4,1'b0,1'b0,2'd2}, {3'd2,3'd4,1'b1,1'b1,2'd2},
    {3'd3,3'd4,1'b0,1'b0,2'd2}, {3'd4,3'd4,1'b1,1'b1,2'd2},                             // R9
    {3'd5,3'd1,1'b1,1'b1,2'd0}, {3'd1,3'd6,1'b0,1'b0,2'd1}                              // R12
  };

  function automatic string tag_of(input logic [2:0] c, input logic [2:0] m);
    if (m > 3'd4 || c > 3'd4) return "R12";
    case (m)
      3'd0: return "R5";
      3'd1: return (c >= 3'd3) ? "R10" : "R6";
      3'd2: return "R4";
      3'd3: return (c >= 3'd3) ? "R10" : (c == 3'd0 ? "R8" : "R7");
      default: return "R9";
    endcase
  endfunction

  // independent model, written per class (hypervisor present)
  function automatic logic [1:0] model(input logic [2:0] c, input logic [2:0] m,
                                       input logic a, input logic b);
    if (m > 3'd4) return 2'd1;
    if (m == 3'd2) return (c > 3'd4) ? 2'd0 : 2'd1;
    case (c)
      3'd0: return (m == 3'd4 || (m == 3'd3 && b)) ? 2'd2 : ((m == 3'd1 && a) ? 2'd1 : 2'd0);
      3'd1: return (m >= 3'd3) ? 2'd2 : 2'd0;
      3'd2: return (m >= 3'd3) ? 2'd2 : ((m == 3'd1 && a) ? 2'd1 : 2'd0);
      3'd3, 3'd4: return (m == 3'd4) ? 2'd2 : 2'd0;
      default: return 2'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // called at a negedge; leaves at the negedge after the result register loads
  task automatic issue(input logic [2:0] c, input logic [2:0] m, input logic a, input logic b);
    req_class = c; priv_mode = m; tvm = a; vtvm = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_class = '0; priv_mode = '0; tvm = 1'b0; vtvm = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", v0, 0, "rsp_valid in reset");
    check("R1", t0, 0, "rsp_trap in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", v0, 0, "rsp_valid after reset");

    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i][9:7], VEC[i][6:4], VEC[i][3], VEC[i][2]);
      check("R2", v0, 1, "valid strobe");
      check(tag_of(VEC[i][9:7], VEC[i][6:4]), t0, VEC[i][1:0],
            $sformatf("table row %0d", i));
    end

    // exhaustive sweep against the model
    for (int c = 0; c < 8; c++)
      for (int m = 0; m < 8; m++)
        for (int k = 0; k < 4; k++) begin
          issue(c[2:0], m[2:0], k[1], k[0]);
          check(tag_of(c[2:0], m[2:0]), t0, model(c[2:0], m[2:0], k[1], k[0]),
                $sformatf("sweep c=%0d m=%0d tvm=%0d vtvm=%0d", c, m, k[1], k[0]));
        end

    // R3 hold: get a virtual trap, then idle with changed inputs
    issue(3'd1, 3'd4, 1'b0, 1'b0);
    req_class = 3'd0; priv_mode = 3'd0; tvm = 1'b0; vtvm = 1'b0;
    @(negedge clk);
    check("R2", v0, 0, "valid drops after lone request");
    check("R3", t0, 2, "trap held while idle");
    @(negedge clk);
    check("R3", t0, 2, "trap still held");

    // R2 back to back requests
    req_class = 3'd0; priv_mode = 3'd1; tvm = 1'b1; vtvm = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    check("R2", v0, 1, "first of pair valid");
    check("R6", t0, 1, "first of pair");
    req_class = 3'd0; priv_mode = 3'd3; tvm = 1'b0; vtvm = 1'b1;
    @(negedge clk);
    check("R2", v0, 1, "second of pair valid");
    check("R8", t0, 2, "second of pair");
    req_valid = 1'b0;
    @(negedge clk);
    check("R2", v0, 0, "valid drops after pair");

    // R11 on the instance without hypervisor
    for (int m = 0; m < 5; m++)
      for (int c = 1; c < 3; c++) begin
        issue(c[2:0], m[2:0], 1'b0, 1'b0);
        check("R11", t1, 1, $sformatf("no-hyp guest c=%0d m=%0d", c, m));
      end
    issue(3'd0, 3'd0, 1'b1, 1'b1);
    check("R11", t1, 0, "no-hyp supervisor invalidate in machine mode");
    issue(3'd3, 3'd1, 1'b1, 1'b1);
    check("R11", t1, 0, "no-hyp fence in supervisor mode");

    // R1 reset mid-stream
    issue(3'd0, 3'd2, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", t0, 0, "trap cleared by reset");
    check("R1", v0, 0, "valid cleared by reset");
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule